// File: doc/BRIEF.md
# Windowed Register File with Spill and Fill Handshake

This block is the integer register file of a small RISC-style core in which every routine sees the same 32 architectural register numbers, while the storage behind them is a larger physical array cut into windows. A current-window pointer selects which slice of the array the windowed names reach. Every window owns eight private locals. Its eight "in" registers are the same physical storage as the eight "out" registers of the routine that called it, so arguments and results pass between caller and callee without any copying. Eight global registers sit outside the windows and look the same from every routine.

A call moves the pointer forward one window and a return moves it back. The array is a ring of eight windows, and because of the shared groups at most seven of them can be live at one time. A call made while seven windows are live must first have the oldest window saved to memory. A return into a window that was saved must first have it brought back. The block asks for both transfers over valid/ready handshakes and stalls the call or return until the transfer is acknowledged. The engine that moves the data is outside the block.

Call and return requests follow the same valid/ready rule. `call_req` or `ret_req` is the valid signal and `ctl_ready` is the ready signal. A requester holds its request steady until it sees `ctl_ready` high at a rising edge, and the operation takes effect at that edge. `spill_valid` and `fill_valid` stay high, with a stable window index, until the matching ready signal is seen. The transfer engine may hold its ready signal low for any number of cycles.

Top module: `rwin_regfile`

## Requirements
- R1: The architectural register number `a[4:0]` decodes by `a[4:3]` as follows: 0 gives global `a[2:0]`, 1 gives out register `a[2:0]`, 2 gives local `a[2:0]`, and 3 gives in register `a[2:0]`. After a call, in register k of the callee holds the value that out register k of the caller held.
- R2: Writing register 0 has no effect, and both read ports return zero for register 0.
- R3: When a read port addresses the same physical register that is being written in the same cycle, that read returns the value being written.
- R4: Reads are combinational from the current window. A write lands at the rising edge and is visible from the next cycle onward.
- R5: A call made while fewer than seven windows are live is accepted at once (`ctl_ready`=1). `cur_win` then reads (old+1) mod 8 from the next cycle.
- R6: A call made while seven windows are live raises `spill_valid`, with `spill_win` = (`cur_win` − 6) mod 8, which is the oldest live window. `ctl_ready` stays low until `spill_ready` is high. In the acknowledging cycle the call completes, `cur_win` advances, and `saved_cnt` increases by one.
- R7: A return made while more than one window is live is accepted at once. `cur_win` then reads (old−1) mod 8.
- R8: A return made while only one window is live and `saved_cnt` > 0 raises `fill_valid`, with `fill_win` = (`cur_win` − 1) mod 8. `ctl_ready` stays low until `fill_ready` is high. In the acknowledging cycle `cur_win` steps back and `saved_cnt` decreases by one.
- R9: A return made with one live window and `saved_cnt` = 0 is accepted (`ctl_ready`=1) but changes neither the pointer nor any register.
- R10: When `call_req` and `ret_req` are both high, the return is ignored and the call proceeds under R5 or R6.
- R11: Local registers are private to their window. A callee's writes to its locals do not change the caller's locals, which read back unchanged after the return.
- R12: After reset, `cur_win`=0, `saved_cnt`=0, one window is live, no spill or fill request is raised, and `ctl_ready` is 0 while no request is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd0_addr | input | 5 | Architectural register number for read port 0 |
| rd0_data | output | 32 | Read port 0 data |
| rd1_addr | input | 5 | Architectural register number for read port 1 |
| rd1_data | output | 32 | Read port 1 data |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Architectural register number to write |
| wr_data | input | 32 | Write data |
| call_req | input | 1 | Call request (valid) |
| ret_req | input | 1 | Return request (valid) |
| ctl_ready | output | 1 | The call or return completes at this edge |
| spill_valid | output | 1 | Request to save a window to memory |
| spill_ready | input | 1 | The spill transfer is acknowledged |
| spill_win | output | 3 | Physical window to be saved |
| fill_valid | output | 1 | Request to restore a window from memory |
| fill_ready | input | 1 | The fill transfer is acknowledged |
| fill_win | output | 3 | Physical window to be restored |
| cur_win | output | 3 | Current window pointer |
| saved_cnt | output | 8 | Number of windows currently saved to memory |

## Verification
The assertions check the handshake and pointer rules on every cycle. They cover pointer motion on accepted calls and returns, spill requests holding stable until acknowledged, the saved count moving with each spill, fill requests appearing only when something is saved, spill and fill never being raised together, the live-window count staying in range, and register 0 reading zero. The bench's scenarios are the only evidence for the data behaviours. These are the caller's out registers reappearing as the callee's ins, locals surviving a nested call, same-cycle write forwarding, a return at the outermost level leaving all state alone, and call taking priority over return. A reference model that follows the window depth checks them against a random mix of calls, returns, writes and stalled acknowledges.

// File: rtl/rwin_pkg.sv
package rwin_pkg;
  // Register group selected by the top two bits of an architectural number.
  typedef enum logic [1:0] {
    GRP_GLOBAL = 2'd0,
    GRP_OUT    = 2'd1,
    GRP_LOCAL  = 2'd2,
    GRP_IN     = 2'd3
  } grp_e;
endpackage

// File: rtl/rwin_xlate.sv
// Maps an architectural register number and a window pointer to a physical index.
// Physical layout: globals first, then per window a shared block (this window's
// ins, the previous window's outs) followed by a private block of locals.
module rwin_xlate
  import rwin_pkg::*;
#(
  parameter int GRP  = 8,
  parameter int NWIN = 8,
  parameter int AW   = 5,
  parameter int WW   = 3,
  parameter int PW   = 8
) (
  input  logic [AW-1:0] arch,
  input  logic [WW-1:0] win,
  output logic [PW-1:0] phys
);
  localparam int GW     = $clog2(GRP);
  localparam int STRIDE = 2 * GRP;

  grp_e          grp;
  logic [GW-1:0] off;
  logic [WW-1:0] nxt_win;

  assign grp     = grp_e'(arch[AW-1 -: 2]);
  assign off     = arch[GW-1:0];
  assign nxt_win = win + WW'(1);

  always_comb begin
    unique case (grp)
      GRP_GLOBAL: phys = PW'(off);
      GRP_OUT:    phys = PW'(GRP + int'(nxt_win) * STRIDE + int'(off));
      GRP_LOCAL:  phys = PW'(GRP + int'(win) * STRIDE + GRP + int'(off));
      default:    phys = PW'(GRP + int'(win) * STRIDE + int'(off));
    endcase
  end
endmodule

// File: rtl/rwin_array.sv
// Physical storage: one write port and NRD combinational read ports with
// write-to-read forwarding. Physical entry 0 is the hard-wired zero.
module rwin_array #(
  parameter int DW    = 32,
  parameter int NPHYS = 136,
  parameter int PW    = 8,
  parameter int NRD   = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [PW-1:0]           wa,
  input  logic [DW-1:0]           wd,
  input  logic [NRD-1:0][PW-1:0]  ra,
  output logic [NRD-1:0][DW-1:0]  rd
);
  logic [DW-1:0] mem [NPHYS];
  logic          wr_live;

  assign wr_live = we && (wa != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPHYS; i++) mem[i] <= '0;
    end else if (wr_live) begin
      mem[wa] <= wd;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_comb begin
      if (ra[p] == '0)                  rd[p] = '0;
      else if (wr_live && wa == ra[p])  rd[p] = wd;
      else                              rd[p] = mem[ra[p]];
    end
  end
endmodule

// File: rtl/rwin_ctrl.sv
// Window pointer, live-window count and saved count, with the spill and fill
// handshakes that gate calls and returns.
module rwin_ctrl #(
  parameter int NWIN   = 8,
  parameter int SAVE_W = 8,
  parameter int WW     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              call_req,
  input  logic              ret_req,
  output logic              ctl_ready,
  output logic              spill_valid,
  input  logic              spill_ready,
  output logic [WW-1:0]     spill_win,
  output logic              fill_valid,
  input  logic              fill_ready,
  output logic [WW-1:0]     fill_win,
  output logic [WW-1:0]     cwp_o,
  output logic [WW-1:0]     res_o,
  output logic [SAVE_W-1:0] saved_o
);
  localparam logic [WW-1:0] RES_MAX = WW'(NWIN - 1);
  localparam logic [WW-1:0] ONE     = WW'(1);

  logic [WW-1:0]     cwp, res;
  logic [SAVE_W-1:0] saved;
  logic              full, base, have_saved, do_ret;

  assign full       = (res == RES_MAX);
  assign base       = (res == ONE);
  assign have_saved = (saved != '0);
  assign do_ret     = ret_req && !call_req;

  assign spill_valid = call_req && full;
  assign spill_win   = cwp - res + ONE;
  assign fill_valid  = do_ret && base && have_saved;
  assign fill_win    = cwp - ONE;

  always_comb begin
    if (call_req)     ctl_ready = !full || spill_ready;
    else if (ret_req) ctl_ready = !base || !have_saved || fill_ready;
    else              ctl_ready = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cwp   <= '0;
      res   <= ONE;
      saved <= '0;
    end else if (ctl_ready) begin
      if (call_req) begin
        cwp <= cwp + ONE;
        if (full) saved <= saved + SAVE_W'(1);
        else      res   <= res + ONE;
      end else if (!base) begin
        cwp <= cwp - ONE;
        res <= res - ONE;
      end else if (have_saved) begin
        cwp   <= cwp - ONE;
        saved <= saved - SAVE_W'(1);
      end
    end
  end

  assign cwp_o   = cwp;
  assign res_o   = res;
  assign saved_o = saved;
endmodule

// File: rtl/rwin_regfile.sv
module rwin_regfile #(
  parameter int DW     = 32,
  parameter int GRP    = 8,
  parameter int NWIN   = 8,
  parameter int SAVE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        rd0_addr,
  output logic [DW-1:0]     rd0_data,
  input  logic [4:0]        rd1_addr,
  output logic [DW-1:0]     rd1_data,
  input  logic              wr_en,
  input  logic [4:0]        wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              call_req,
  input  logic              ret_req,
  output logic              ctl_ready,
  output logic              spill_valid,
  input  logic              spill_ready,
  output logic [2:0]        spill_win,
  output logic              fill_valid,
  input  logic              fill_ready,
  output logic [2:0]        fill_win,
  output logic [2:0]        cur_win,
  output logic [SAVE_W-1:0] saved_cnt
);
  localparam int GW    = $clog2(GRP);
  localparam int AW    = GW + 2;
  localparam int WW    = $clog2(NWIN);
  localparam int NPHYS = GRP + NWIN * 2 * GRP;
  localparam int PW    = $clog2(NPHYS);
  localparam int NRD   = 2;

  logic [WW-1:0]                res_cnt;
  logic [NRD-1:0][AW-1:0]       rd_arch;
  logic [NRD-1:0][PW-1:0]       rd_phys;
  logic [NRD-1:0][DW-1:0]       rd_val;
  logic [PW-1:0]                wr_phys;

  assign rd_arch[0] = AW'(rd0_addr);
  assign rd_arch[1] = AW'(rd1_addr);

  rwin_ctrl #(.NWIN(NWIN), .SAVE_W(SAVE_W), .WW(WW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .call_req(call_req), .ret_req(ret_req), .ctl_ready(ctl_ready),
    .spill_valid(spill_valid), .spill_ready(spill_ready), .spill_win(spill_win),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_win(fill_win),
    .cwp_o(cur_win), .res_o(res_cnt), .saved_o(saved_cnt)
  );

  for (genvar p = 0; p < NRD; p++) begin : g_rx
    rwin_xlate #(.GRP(GRP), .NWIN(NWIN), .AW(AW), .WW(WW), .PW(PW)) u_rx (
      .arch(rd_arch[p]), .win(cur_win), .phys(rd_phys[p])
    );
  end

  rwin_xlate #(.GRP(GRP), .NWIN(NWIN), .AW(AW), .WW(WW), .PW(PW)) u_wx (
    .arch(AW'(wr_addr)), .win(cur_win), .phys(wr_phys)
  );

  rwin_array #(.DW(DW), .NPHYS(NPHYS), .PW(PW), .NRD(NRD)) u_arr (
    .clk(clk), .rst_n(rst_n),
    .we(wr_en), .wa(wr_phys), .wd(wr_data),
    .ra(rd_phys), .rd(rd_val)
  );

  assign rd0_data = rd_val[0];
  assign rd1_data = rd_val[1];
endmodule

// File: rtl/rwin_regfile_chk.sv
module rwin_regfile_chk #(
  parameter int DW     = 32,
  parameter int NWIN   = 8,
  parameter int SAVE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [4:0]        rd0_addr,
  input logic [DW-1:0]     rd0_data,
  input logic              call_req,
  input logic              ret_req,
  input logic              ctl_ready,
  input logic              spill_valid,
  input logic              spill_ready,
  input logic [2:0]        spill_win,
  input logic              fill_valid,
  input logic              fill_ready,
  input logic [2:0]        fill_win,
  input logic [2:0]        cur_win,
  input logic [SAVE_W-1:0] saved_cnt,
  input logic [2:0]        res_cnt
);
  // R5: an accepted call advances the pointer by one
  a_r5_call_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (call_req && ctl_ready) |=> cur_win == $past(cur_win) + 3'd1);

  // R7: an accepted return with several live windows steps back by one
  a_r7_ret_back: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && !call_req && ctl_ready && res_cnt > 3'd1) |=> cur_win == $past(cur_win) - 3'd1);

  // R6: a pending spill holds its request and window until acknowledged
  a_r6_spill_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (spill_valid && !spill_ready) |=> spill_valid && $stable(spill_win));

  // R6: each acknowledged spill adds one saved window
  a_r6_spill_count: assert property (@(posedge clk) disable iff (!rst_n)
    (spill_valid && spill_ready) |=> saved_cnt == $past(saved_cnt) + SAVE_W'(1));

  // R8: a fill is only asked for with one live window and something saved
  a_r8_fill_cause: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> (saved_cnt != '0) && (res_cnt == 3'd1));

  // R8: a pending fill holds its window until acknowledged
  a_r8_fill_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !fill_ready) |=> fill_valid && $stable(fill_win));

  // R10: spill and fill are never requested together
  a_r10_one_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    !(spill_valid && fill_valid));

  // R12: live-window count stays between one and NWIN-1
  a_r12_live_range: assert property (@(posedge clk) disable iff (!rst_n)
    (res_cnt >= 3'd1) && (int'(res_cnt) <= NWIN - 1));

  // R2: register 0 always reads zero
  a_r2_zero_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0_addr == 5'd0) |-> rd0_data == '0);
endmodule

bind rwin_regfile rwin_regfile_chk #(.DW(DW), .NWIN(NWIN), .SAVE_W(SAVE_W)) u_chk (.*);

// File: tb/rwin_regfile_tb.sv
`timescale 1ns/1ps
module rwin_regfile_tb;
  localparam int MAXD = 260;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  rd0_addr = '0, rd1_addr = '0, wr_addr = '0;
  logic [31:0] rd0_data, rd1_data, wr_data = '0;
  logic        wr_en = 1'b0, call_req = 1'b0, ret_req = 1'b0;
  logic        ctl_ready, spill_valid, spill_ready = 1'b0, fill_valid, fill_ready = 1'b0;
  logic [2:0]  spill_win, fill_win, cur_win;
  logic [7:0]  saved_cnt;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rwin_regfile u_dut (.*);

  // Reference model kept in terms of absolute call depth.
  int   dep = 0, resm = 1, savm = 0;
  logic [31:0] gm [8];
  bit          gv [8];
  logic [31:0] lm [MAXD][8];
  bit          lv [MAXD][8];
  logic [31:0] sm [MAXD+1][8];
  bit          sv [MAXD+1][8];

  function automatic int mkey(input int a);
    int o = a % 8;
    case (a / 8)
      0: return o;
      1: return 1000 + (dep + 1) * 8 + o;
      2: return 100000 + dep * 8 + o;
      default: return 1000 + dep * 8 + o;
    endcase
  endfunction

  function automatic bit mget(input int a, output logic [31:0] v);
    int o = a % 8;
    v = '0;
    case (a / 8)
      0: begin if (o == 0) return 1'b1; v = gm[o]; return gv[o]; end
      1: begin v = sm[dep+1][o]; return sv[dep+1][o]; end
      2: begin v = lm[dep][o];   return lv[dep][o];   end
      default: begin v = sm[dep][o]; return sv[dep][o]; end
    endcase
  endfunction

  task automatic mset(input int a, input logic [31:0] v);
    int o = a % 8;
    case (a / 8)
      0: if (o != 0) begin gm[o] = v; gv[o] = 1'b1; end
      1: begin sm[dep+1][o] = v; sv[dep+1][o] = 1'b1; end
      2: begin lm[dep][o] = v;   lv[dep][o] = 1'b1;   end
      default: begin sm[dep][o] = v; sv[dep][o] = 1'b1; end
    endcase
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One cycle: inputs set at negedge, outputs checked shortly after, model
  // advanced at the rising edge.
  task automatic cyc(input bit c, input bit r, input bit we, input int wa,
                     input logic [31:0] wd, input int a0, input int a1,
                     input bit sr, input bit fr, output bit fired);
    bit e_spill, e_fill, e_ready;
    logic [31:0] v;
    call_req = c; ret_req = r; wr_en = we; wr_addr = 5'(wa); wr_data = wd;
    rd0_addr = 5'(a0); rd1_addr = 5'(a1); spill_ready = sr; fill_ready = fr;
    #1;
    e_spill = c && resm == 7;
    e_fill  = !c && r && resm == 1 && savm > 0;
    e_ready = c ? (resm < 7 || sr) : r ? (resm > 1 || savm == 0 || fr) : 1'b0;
    chk("R5/R6/R8 ctl_ready", 32'(ctl_ready), 32'(e_ready));
    chk("R6 spill_valid", 32'(spill_valid), 32'(e_spill));
    chk("R8/R10 fill_valid", 32'(fill_valid), 32'(e_fill));
    if (e_spill) chk("R6 spill_win", 32'(spill_win), 32'((dep - 6) & 7));
    if (e_fill)  chk("R8 fill_win", 32'(fill_win), 32'((dep - 1) & 7));
    chk("R5/R7 cur_win", 32'(cur_win), 32'(dep & 7));
    chk("R6/R8 saved_cnt", 32'(saved_cnt), 32'(savm));
    if (mget(a0, v)) begin
      if (a0 == 0) v = '0;
      else if (we && wa != 0 && mkey(wa) == mkey(a0)) v = wd;
      chk("R1/R3/R4/R11 rd0", rd0_data, v);
    end
    if (mget(a1, v)) begin
      if (a1 == 0) v = '0;
      else if (we && wa != 0 && mkey(wa) == mkey(a1)) v = wd;
      chk("R1/R3/R4/R11 rd1", rd1_data, v);
    end
    @(posedge clk);
    fired = e_ready;
    if (we) mset(wa, wd);
    if (e_ready) begin
      if (c) begin
        if (resm == 7) begin
          int od = dep - 6;
          savm++;
          for (int k = 0; k < 8; k++) begin lv[od][k] = 1'b0; sv[od][k] = 1'b0; end
        end else resm++;
        dep++;
        for (int k = 0; k < 8; k++) begin lv[dep][k] = 1'b0; sv[dep+1][k] = 1'b0; end
      end else if (resm > 1) begin dep--; resm--; end
      else if (savm > 0) begin dep--; savm--; end
    end
    @(negedge clk);
  endtask

  task automatic idle_read(input int a0, input int a1);
    bit f;
    cyc(1'b0, 1'b0, 1'b0, 0, '0, a0, a1, 1'b0, 1'b0, f);
  endtask

  task automatic do_call(input int stall);
    bit f = 1'b0;
    int n = 0;
    while (!f) begin
      cyc(1'b1, 1'b0, 1'b0, 0, '0, 8, 24, n >= stall, 1'b0, f);
      n++;
    end
  endtask

  task automatic do_ret(input int stall);
    bit f = 1'b0;
    int n = 0;
    while (!f) begin
      cyc(1'b0, 1'b1, 1'b0, 0, '0, 16, 24, 1'b0, n >= stall, f);
      n++;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R12 actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    bit f;
    bit pc = 1'b0, pr = 1'b0;
    void'($urandom(32'h1d5e_a7c3));
    for (int i = 0; i < 8; i++) gv[i] = 1'b0;
    for (int d = 0; d < MAXD; d++)
      for (int k = 0; k < 8; k++) begin lv[d][k] = 1'b0; sv[d][k] = 1'b0; end
    for (int k = 0; k < 8; k++) sv[MAXD][k] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12: reset state with no request present
    #1;
    chk("R12 cur_win", 32'(cur_win), 0);
    chk("R12 saved_cnt", 32'(saved_cnt), 0);
    chk("R12 spill_valid", 32'(spill_valid), 0);
    chk("R12 fill_valid", 32'(fill_valid), 0);
    chk("R12 ctl_ready", 32'(ctl_ready), 0);
    @(negedge clk);

    // R2: write to register 0 ignored, read of 0 gives zero
    cyc(1'b0, 1'b0, 1'b1, 0, 32'hdead_beef, 0, 0, 1'b0, 1'b0, f);
    idle_read(0, 0);
    chk("R2 rd0 zero", rd0_data, 0);

    // R3: forwarding of a same-cycle write
    cyc(1'b0, 1'b0, 1'b1, 17, 32'h1111_0017, 17, 3, 1'b0, 1'b0, f);
    cyc(1'b0, 1'b0, 1'b1, 9, 32'h2222_0009, 9, 17, 1'b0, 1'b0, f);

    // R1: out register 1 of the caller is in register 1 of the callee
    do_call(0);
    idle_read(25, 16 + 1);
    chk("R1 out->in", rd0_data, 32'h2222_0009);
    // R11: callee writes its local 1; caller's local 1 survives the return
    cyc(1'b0, 1'b0, 1'b1, 17, 32'h3333_0017, 17, 25, 1'b0, 1'b0, f);
    do_ret(0);
    idle_read(17, 9);
    chk("R11 caller local kept", rd0_data, 32'h1111_0017);

    // R9: return at outermost level has no effect
    cyc(1'b0, 1'b1, 1'b0, 0, '0, 17, 9, 1'b0, 1'b0, f);
    chk("R9 ret accepted", 32'(f), 1);
    idle_read(17, 9);
    chk("R9 pointer unchanged", 32'(cur_win), 0);

    // R10: call and return together act as a call
    cyc(1'b1, 1'b1, 1'b0, 0, '0, 8, 24, 1'b0, 1'b0, f);
    idle_read(8, 24);
    chk("R10 call wins", 32'(cur_win), 1);

    // R6: deep calls force spills, with stalled acknowledges
    for (int i = 0; i < 9; i++) do_call(2);
    chk("R6 saved after deep calls", 32'(saved_cnt), 4);
    // R8: unwinding forces fills, with stalled acknowledges
    for (int i = 0; i < 10; i++) do_ret(3);
    chk("R8 back to outer", 32'(cur_win), 0);
    chk("R8 saved drained", 32'(saved_cnt), 0);

    // Random traffic
    for (int n = 0; n < 6000; n++) begin
      int wa, a0, a1;
      bit we;
      if (!pc && !pr) begin
        int x = $urandom_range(0, 99);
        pc = (x < 12) && dep < MAXD - 20;
        pr = (x >= 12 && x < 24);
        if (x == 5) pr = 1'b1;
      end
      we = $urandom_range(0, 1);
      wa = $urandom_range(0, 31);
      a0 = $urandom_range(0, 3) == 0 ? wa : $urandom_range(0, 31);
      a1 = $urandom_range(0, 31);
      cyc(pc, pr, we, wa, $urandom, a0, a1,
          $urandom_range(0, 2) == 0, $urandom_range(0, 2) == 0, f);
      if (f) begin pc = 1'b0; pr = 1'b0; end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule